// File: doc/BRIEF.md
# Two-Stage SPI Clock Prescaler

This block derives the serial clock of an SPI master from the main clock. The divide has two stages. A power-of-two prescaler divides the main clock by `2 << div_sel`. A second counter then divides that result by `2*(rate_sel+1)`. The two selectors are held in configuration registers. They can be rewritten only while the device-enable input is low, so the rate never changes partway through a word.

While a transfer runs, the block outputs the serial clock and two one-cycle strobes, one for each clock edge, for a neighbouring shifter to use. The leading strobe marks the edge that leaves the idle level. The trailing strobe marks the edge that returns to it. The idle level is set by a clock-invert input.

A small helper, separate from the divider, picks selector values for a requested rate. It is given the integer quotient of the main clock frequency over the wanted SPI frequency. It tries prescale settings from the smallest upward and clamps requests that are too fast or too slow to the nearest legal setting.

Top module: `spi_sclk_prescaler`

## Requirements
- R1: After reset the selectors are div_sel=0 and rate_sel=4. `sclk` equals `cpol`, both strobes are low and `calc_done` is low. A transfer started with no load has a half period of 10 main cycles.
- R2: While `enable` and `active` are both high, `sclk` toggles every H = (2 << div_sel) * (rate_sel+1) main cycles. The first toggle is due H rising edges after the first edge at which both inputs are sampled high.
- R3: The fastest setting (div_sel=0, rate_sel=4) gives a period of 20 main cycles. The slowest setting (div_sel=3, rate_sel=63) gives a period of 2048.
- R4: A `cfg_brg` value below 4 is stored as 4. Values 4 to 63 are stored as given.
- R5: A `cfg_load` pulse while `enable` is high has no effect on the selectors.
- R6: Whenever `enable` or `active` was low at the last rising edge, `sclk` equals `cpol` and both strobes are low.
- R7: `tick_lead` pulses for one cycle on each edge that leaves the idle level. `tick_trail` pulses for one cycle on each edge that returns to it. The two strobes are never high together.
- R8: One cycle after `calc_go`, `calc_done` is high. `calc_div` and `calc_brg` then hold the first d in 0,1,2,3 for which q = floor(calc_ratio / (4 << d)) is at most 64, and q-1 for that d.
- R9: If floor(calc_ratio/4) is below 5, the helper returns div 0 and brg 4.
- R10: If no d gives q at most 64 (calc_ratio of 2080 or more), the helper returns div 3 and brg 63.
- R11: With `cpol`=1 the clock idles high and the leading edge drives it low. With `cpol`=0 the clock idles low and the leading edge drives it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Device enable; the selectors can be loaded only while it is low |
| active | input | 1 | Transfer in progress; the clock runs while this and enable are both high |
| cpol | input | 1 | Clock invert: idle level of sclk |
| cfg_load | input | 1 | Load strobe for the selectors |
| cfg_div | input | DIV_W | Prescale selector to load |
| cfg_brg | input | BRG_W | Second-stage selector to load |
| calc_go | input | 1 | Start a rate search |
| calc_ratio | input | RATIO_W | Main clock frequency divided by the wanted SPI frequency |
| sclk | output | 1 | Serial clock |
| tick_lead | output | 1 | One-cycle strobe on each edge that leaves idle |
| tick_trail | output | 1 | One-cycle strobe on each edge that returns to idle |
| calc_done | output | 1 | Search result valid |
| calc_div | output | DIV_W | Prescale selector found by the search |
| calc_brg | output | BRG_W | Second-stage selector found by the search |

## Verification
Every output comes from a register, so a strobe and its matching sclk change appear together, H rising edges after the first edge that samples the transfer as running. The idle level appears one edge after the run condition drops, and a search result appears one edge after `calc_go`. The bench drives inputs on the falling edge and counts rising edges from the edge at which the run condition first takes effect. For each configuration it predicts the level and both strobes at every count over two full periods, and samples on the falling edge that follows each rising edge. A config load is issued one edge before enable rises, so the new selectors are in place for the first counted edge.

// File: rtl/spi_pre_pkg.sv
package spi_pre_pkg;
  // Kind of serial-clock edge produced in a given cycle
  typedef enum logic [1:0] {
    EDGE_NONE  = 2'd0,
    EDGE_LEAD  = 2'd1,
    EDGE_TRAIL = 2'd2
  } edge_e;
endpackage

// File: rtl/spi_pre_cfg.sv
module spi_pre_cfg #(
  parameter int DIV_W   = 2,
  parameter int BRG_W   = 6,
  parameter int BRG_MIN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             cfg_load,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [BRG_W-1:0] cfg_brg,
  output logic [DIV_W-1:0] div_q,
  output logic [BRG_W-1:0] brg_q
);
  localparam logic [BRG_W-1:0] BRG_FLOOR = BRG_W'(BRG_MIN);

  logic [BRG_W-1:0] brg_legal;

  // values under the legal floor are raised to it
  always_comb begin
    brg_legal = (cfg_brg < BRG_FLOOR) ? BRG_FLOOR : cfg_brg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      brg_q <= BRG_FLOOR;
    end else if (cfg_load && !enable) begin
      div_q <= cfg_div;
      brg_q <= brg_legal;
    end
  end
endmodule

// File: rtl/spi_pre_divider.sv
module spi_pre_divider
  import spi_pre_pkg::*;
#(
  parameter int DIV_W = 2,
  parameter int BRG_W = 6,
  parameter int PRE_W = 1 << DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             cpol,
  input  logic [DIV_W-1:0] div_q,
  input  logic [BRG_W-1:0] brg_q,
  output logic             sclk,
  output logic             tick_lead,
  output logic             tick_trail
);
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_last;
  logic [BRG_W-1:0] brg_cnt;
  logic             phase;
  logic             phase_nx;
  logic             pre_wrap;
  logic             brg_wrap;
  logic             flip;
  edge_e            kind;

  // terminal count of the prescaler: (2 << div) - 1
  always_comb begin
    pre_last = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i <= int'(div_q)) pre_last[i] = 1'b1;
    end
  end

  always_comb begin
    pre_wrap = (pre_cnt == pre_last);
    brg_wrap = (brg_cnt == brg_q);
    flip     = run && pre_wrap && brg_wrap;
    phase_nx = phase ^ flip;
    if (!flip)      kind = EDGE_NONE;
    else if (phase) kind = EDGE_TRAIL;
    else            kind = EDGE_LEAD;
  end

  // stage one: power-of-two prescale, stage two: (brg+1) strobes per half period
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_cnt <= '0;
      brg_cnt <= '0;
      phase   <= 1'b0;
    end else begin
      pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
      if (pre_wrap) brg_cnt <= brg_wrap ? '0 : brg_cnt + 1'b1;
      phase <= phase_nx;
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk       <= cpol;
      tick_lead  <= 1'b0;
      tick_trail <= 1'b0;
    end else begin
      sclk       <= cpol ^ (run && phase_nx);
      tick_lead  <= (kind == EDGE_LEAD);
      tick_trail <= (kind == EDGE_TRAIL);
    end
  end
endmodule

// File: rtl/spi_pre_search.sv
module spi_pre_search #(
  parameter int DIV_W   = 2,
  parameter int BRG_W   = 6,
  parameter int BRG_MIN = 4,
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               calc_go,
  input  logic [RATIO_W-1:0] calc_ratio,
  output logic               calc_done,
  output logic [DIV_W-1:0]   calc_div,
  output logic [BRG_W-1:0]   calc_brg
);
  localparam int NDIV = 1 << DIV_W;
  localparam int LIM  = 1 << BRG_W;

  logic [RATIO_W-1:0] quo [NDIV];
  logic [DIV_W-1:0]   sel_div;
  logic [BRG_W:0]     sel_p1;
  logic               found;

  // quotient for each prescale choice: ratio / (4 << d)
  for (genvar g = 0; g < NDIV; g++) begin : g_quo
    assign quo[g] = calc_ratio >> (2 + g);
  end

  always_comb begin
    found   = 1'b0;
    sel_div = DIV_W'(NDIV - 1);
    sel_p1  = (BRG_W+1)'(LIM);
    if (quo[0] < RATIO_W'(BRG_MIN + 1)) begin
      found   = 1'b1;
      sel_div = '0;
      sel_p1  = (BRG_W+1)'(BRG_MIN + 1);
    end
    for (int d = 0; d < NDIV; d++) begin
      if (!found && quo[d] <= RATIO_W'(LIM)) begin
        found   = 1'b1;
        sel_div = DIV_W'(d);
        sel_p1  = quo[d][BRG_W:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      calc_done <= 1'b0;
      calc_div  <= '0;
      calc_brg  <= BRG_W'(BRG_MIN);
    end else begin
      calc_done <= calc_go;
      if (calc_go) begin
        calc_div <= sel_div;
        calc_brg <= BRG_W'(sel_p1 - (BRG_W+1)'(1));
      end
    end
  end
endmodule

// File: rtl/spi_sclk_prescaler.sv
module spi_sclk_prescaler #(
  parameter int DIV_W   = 2,
  parameter int BRG_W   = 6,
  parameter int BRG_MIN = 4,
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               active,
  input  logic               cpol,
  input  logic               cfg_load,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic [BRG_W-1:0]   cfg_brg,
  input  logic               calc_go,
  input  logic [RATIO_W-1:0] calc_ratio,
  output logic               sclk,
  output logic               tick_lead,
  output logic               tick_trail,
  output logic               calc_done,
  output logic [DIV_W-1:0]   calc_div,
  output logic [BRG_W-1:0]   calc_brg
);
  localparam int PRE_W = 1 << DIV_W;

  logic [DIV_W-1:0] div_q;
  logic [BRG_W-1:0] brg_q;
  logic             run;

  assign run = enable && active;

  spi_pre_cfg #(.DIV_W(DIV_W), .BRG_W(BRG_W), .BRG_MIN(BRG_MIN)) u_cfg (
    .clk(clk), .rst(rst), .enable(enable), .cfg_load(cfg_load),
    .cfg_div(cfg_div), .cfg_brg(cfg_brg), .div_q(div_q), .brg_q(brg_q)
  );

  spi_pre_divider #(.DIV_W(DIV_W), .BRG_W(BRG_W), .PRE_W(PRE_W)) u_div (
    .clk(clk), .rst(rst), .run(run), .cpol(cpol), .div_q(div_q),
    .brg_q(brg_q), .sclk(sclk), .tick_lead(tick_lead), .tick_trail(tick_trail)
  );

  spi_pre_search #(.DIV_W(DIV_W), .BRG_W(BRG_W), .BRG_MIN(BRG_MIN),
                   .RATIO_W(RATIO_W)) u_search (
    .clk(clk), .rst(rst), .calc_go(calc_go), .calc_ratio(calc_ratio),
    .calc_done(calc_done), .calc_div(calc_div), .calc_brg(calc_brg)
  );
endmodule

// File: rtl/spi_sclk_prescaler_chk.sv
module spi_sclk_prescaler_chk #(
  parameter int DIV_W   = 2,
  parameter int BRG_W   = 6,
  parameter int BRG_MIN = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             active,
  input logic             cpol,
  input logic             sclk,
  input logic             tick_lead,
  input logic             tick_trail,
  input logic [DIV_W-1:0] div_q,
  input logic [BRG_W-1:0] brg_q,
  input logic             calc_go,
  input logic             calc_done,
  input logic [BRG_W-1:0] calc_brg
);
  assert_ticks_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tick_lead, tick_trail}));

  assert_tick_needs_run_R6: assert property (@(posedge clk) disable iff (rst)
    (tick_lead || tick_trail) |-> $past(enable && active));

  assert_idle_level_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(enable && active) && !$past(rst)) |-> (sclk == $past(cpol)));

  assert_lead_leaves_idle_R11: assert property (@(posedge clk) disable iff (rst)
    tick_lead |-> (sclk != $past(cpol)));

  assert_trail_returns_R7: assert property (@(posedge clk) disable iff (rst)
    tick_trail |-> (sclk == $past(cpol)));

  assert_cfg_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(enable) && !$past(rst)) |-> ($stable(div_q) && $stable(brg_q)));

  assert_brg_floor_R4: assert property (@(posedge clk) disable iff (rst)
    brg_q >= BRG_W'(BRG_MIN));

  assert_search_legal_R8: assert property (@(posedge clk) disable iff (rst)
    calc_done |-> (calc_brg >= BRG_W'(BRG_MIN)));

  assert_done_after_go_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(calc_go) && !$past(rst)) |-> calc_done);
endmodule

bind spi_sclk_prescaler spi_sclk_prescaler_chk #(
  .DIV_W(DIV_W), .BRG_W(BRG_W), .BRG_MIN(BRG_MIN)
) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .active(active), .cpol(cpol),
  .sclk(sclk), .tick_lead(tick_lead), .tick_trail(tick_trail),
  .div_q(div_q), .brg_q(brg_q), .calc_go(calc_go), .calc_done(calc_done),
  .calc_brg(calc_brg)
);

// File: tb/spi_sclk_prescaler_test.sv
`timescale 1ns/1ps
module spi_sclk_prescaler_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic        active = 1'b0;
  logic        cpol = 1'b0;
  logic        cfg_load = 1'b0;
  logic [1:0]  cfg_div = '0;
  logic [5:0]  cfg_brg = '0;
  logic        calc_go = 1'b0;
  logic [15:0] calc_ratio = '0;
  logic        sclk, tick_lead, tick_trail, calc_done;
  logic [1:0]  calc_div;
  logic [5:0]  calc_brg;

  int compared = 0;
  int mismatched = 0;
  int meas_period;
  int first_edge;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  spi_sclk_prescaler uut (
    .clk(clk), .rst(rst), .enable(enable), .active(active), .cpol(cpol),
    .cfg_load(cfg_load), .cfg_div(cfg_div), .cfg_brg(cfg_brg),
    .calc_go(calc_go), .calc_ratio(calc_ratio), .sclk(sclk),
    .tick_lead(tick_lead), .tick_trail(tick_trail), .calc_done(calc_done),
    .calc_div(calc_div), .calc_brg(calc_brg)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // load selectors with enable low, run two periods, predict every cycle
  task automatic measure(input int dv, input int bg, input bit pol, input string req);
    int be, h, bad, k, lead1, lead2;
    bit es, el, et;
    be = (bg < 4) ? 4 : bg;
    h = (2 << dv) * (be + 1);
    bad = 0; lead1 = -1; lead2 = -1;
    @(negedge clk);
    enable = 1'b0; active = 1'b0; cpol = pol;
    cfg_div = 2'(dv); cfg_brg = 6'(bg); cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    check(sclk == pol && !tick_lead && !tick_trail, "R6", int'(sclk), int'(pol));
    enable = 1'b1; active = 1'b1;
    for (int c = 1; c <= 4 * h; c++) begin
      @(negedge clk);
      k  = c / h;
      el = (c % h == 0) && (k % 2 == 1);
      et = (c % h == 0) && (k % 2 == 0);
      es = pol ^ k[0];
      if (tick_lead) begin
        if (lead1 < 0) lead1 = c; else if (lead2 < 0) lead2 = c;
      end
      if (sclk != es || tick_lead != el || tick_trail != et) bad++;
    end
    meas_period = lead2 - lead1;
    check(bad == 0, req, bad, 0);
    check(meas_period == 2 * h, req, meas_period, 2 * h);
    enable = 1'b0; active = 1'b0;
    @(negedge clk);
    check(sclk == pol && !tick_lead && !tick_trail, "R6", int'(sclk), int'(pol));
  endtask

  // count edges from run start to the first strobe
  task automatic time_first_edge();
    first_edge = -1;
    for (int c = 1; c <= 5000; c++) begin
      @(negedge clk);
      if (tick_lead || tick_trail) begin
        first_edge = c;
        break;
      end
    end
  endtask

  function automatic int model_search(input int r);
    int q;
    if (r / 4 < 5) return 4;          // div 0, brg 4
    for (int d = 0; d < 4; d++) begin
      q = r / (4 << d);
      if (q <= 64) return (d << 8) | (q - 1);
    end
    return (3 << 8) | 63;
  endfunction

  task automatic do_search(input int r);
    int m, got;
    string req;
    m = model_search(r);
    if (r / 4 < 5) req = "R9";
    else if (r >= 2080) req = "R10";
    else req = "R8";
    @(negedge clk);
    calc_ratio = 16'(r); calc_go = 1'b1;
    @(negedge clk);
    calc_go = 1'b0;
    got = (int'(calc_div) << 8) | int'(calc_brg);
    check(calc_done && got == m, req, got, m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(sclk == 1'b0 && !tick_lead && !tick_trail, "R1", int'(sclk), 0);
    check(calc_done == 1'b0, "R1", int'(calc_done), 0);
    enable = 1'b1; active = 1'b1;
    time_first_edge();
    check(first_edge == 10, "R1", first_edge, 10);
    enable = 1'b0; active = 1'b0;
    @(negedge clk);

    // R3: extremes of the range
    measure(0, 4, 1'b0, "R3");
    check(meas_period == 20, "R3", meas_period, 20);
    measure(3, 63, 1'b0, "R3");
    check(meas_period == 2048, "R3", meas_period, 2048);

    // R2/R4/R7: sweep div 0 and 1 over every brg (brg < 4 clamps, R4)
    for (int d = 0; d < 2; d++)
      for (int b = 0; b < 64; b++)
        measure(d, b, 1'b0, (b < 4) ? "R4" : "R2");
    // R2: larger prescale at chosen points
    for (int d = 2; d < 4; d++) begin
      measure(d, 0, 1'b0, "R4");
      measure(d, 5, 1'b0, "R2");
      measure(d, 31, 1'b0, "R2");
    end
    // R11: inverted polarity
    measure(0, 4, 1'b1, "R11");
    measure(1, 9, 1'b1, "R11");
    measure(2, 17, 1'b1, "R11");

    // R5: load while enabled is ignored; R6: idle while not active
    measure(0, 4, 1'b0, "R7");
    @(negedge clk);
    cpol = 1'b0; enable = 1'b1; active = 1'b0;
    cfg_div = 2'd2; cfg_brg = 6'd40; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    begin
      int ticks_seen;
      ticks_seen = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (tick_lead || tick_trail || sclk != 1'b0) ticks_seen++;
      end
      check(ticks_seen == 0, "R6", ticks_seen, 0);
    end
    active = 1'b1;
    time_first_edge();
    check(first_edge == 10, "R5", first_edge, 10);
    enable = 1'b0; active = 1'b0;
    @(negedge clk);

    // R8/R9/R10: search sweep
    for (int r = 0; r <= 4200; r++) do_search(r);
    do_search(8191);
    do_search(40000);
    do_search(65535);
    @(negedge clk);
    check(calc_done == 1'b0, "R8", int'(calc_done), 0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule